// File: doc/BRIEF.md
# Segmented Logical Address Translator

This block turns a logical address, given as a segment register number plus a 32-bit offset, into a 32-bit linear address. It keeps six segment selector registers. Each selector has a hidden descriptor cache beside it that holds the segment base, the limit, the privilege level and the executable flag.

Writing a selector starts a descriptor fetch through a simple memory read port. The fetch reads from the global or the local descriptor table, chosen by the selector's table bit. Once the descriptor is captured, every translation for that segment uses only the cached copy and makes no table access.

Two address modes are supported. In legacy mode every segment adds its base and checks its limit. In 64-bit mode only the two auxiliary segments add a base, and no limit check is made.

The descriptor loader is a five-state machine:
- F_IDLE accepts a selector write. It moves to F_READ_LO if the selector is in range, and to F_REJECT if it is not.
- F_READ_LO holds a read of the low descriptor word until the memory answers, then moves to F_READ_HI.
- F_READ_HI does the same for the high word, then moves to F_COMMIT.
- F_COMMIT writes the selector and its decoded descriptor into the bank, then returns to F_IDLE.
- F_REJECT raises the load fault for one cycle, then returns to F_IDLE.

Top module: `seg_xlate_top`

## Requirements
- R1: A selector holds the table index in bits 15:3, the table bit in bit 2 (0 = global table, 1 = local table) and the requested privilege in bits 1:0. A load reads the low descriptor word at table base + index*8, then the high word at that address + 4.
- R2: The descriptor decodes as follows: base = {hi[31:24], hi[7:0], lo[31:16]}, limit = {hi[19:16], lo[15:0]}, privilege = hi[14:13], executable = hi[11]. Each translation reports the privilege on lin_dpl, the executable flag on lin_exec and the segment's selector on lin_sel.
- R3: In legacy mode (mode64 = 0), lin_addr = base + offset modulo 2^32, and lin_fault = 1 exactly when offset > limit.
- R4: In 64-bit mode, segments 0, 1, 2 and 3 (ES, CS, SS, DS) use a base of zero. Segments 4 and 5 (FS, GS) add their cached base. No limit fault is raised.
- R5: A request accepted while xl_valid = 1 and xl_ready = 1 gives lin_valid = 1 with its result in the next cycle. lin_valid is 0 in any cycle that follows a cycle with no accepted request.
- R6: From the cycle after a selector write until its fetch ends, exactly one seg_busy bit is set: the one for the target segment. xl_ready is 0 for that segment only.
- R7: A write with sel_idx >= 6, or with index*8+7 greater than the chosen table limit, pulses load_fault in the cycle after the write. It makes no memory read and leaves the selector and its cache unchanged.
- R8: After a load, translations make no memory access. mem_req is 1 only while ld_ready is 0.
- R9: A selector write presented while ld_ready = 0 is ignored.
- R10: cpl equals bits 1:0 of the CS (segment 1) selector, and changes only when a CS load commits.
- R11: After reset, every cache holds base 0, limit 0xFFFFF, privilege 0 and a clear executable flag. Every selector is 0, cpl = 0, ld_ready = 1, mem_req = 0 and seg_busy = 0.
- R12: A translation naming segment 6 or 7 gives lin_fault = 1 and lin_addr = offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode64 | input | 1 | 1 selects 64-bit address mode |
| gdt_base | input | MEM_AW | Global table base address |
| gdt_limit | input | TLIM_W | Global table byte limit |
| ldt_base | input | MEM_AW | Local table base address |
| ldt_limit | input | TLIM_W | Local table byte limit |
| sel_we | input | 1 | Selector write strobe |
| sel_idx | input | 3 | Target segment (0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS) |
| sel_val | input | 16 | Selector value |
| ld_ready | output | 1 | Loader idle, write accepted |
| load_fault | output | 1 | Rejected selector load pulse |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | MEM_AW | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| xl_valid | input | 1 | Translation request |
| xl_seg | input | 3 | Segment for translation |
| xl_off | input | 32 | Offset |
| xl_ready | output | 1 | Request may be accepted |
| lin_valid | output | 1 | Result valid |
| lin_addr | output | 32 | Linear address |
| lin_fault | output | 1 | Limit or segment fault |
| lin_dpl | output | 2 | Cached privilege level |
| lin_exec | output | 1 | Cached executable flag |
| lin_sel | output | 16 | Selector of the segment used |
| seg_busy | output | 6 | Per-segment fetch pending |
| cpl | output | 2 | Current privilege level |

## Verification
Random selector loads are mixed across both tables. Their indices straddle each table limit, so accepted loads and rejected loads are both exercised, and each one is checked against the descriptor words the bench memory returns.

Offsets are drawn as exactly the limit, the limit plus one, and fully random values. These patterns separate an off-by-one in the limit compare from a missing compare, and they are applied in both modes to tell the per-segment base zeroing apart from a global one.

Directed cases cover:
- the table-boundary indices;
- an out-of-range segment number, for both a load and a translation;
- the privilege taken from CS;
- a write and a translation that arrive while a fetch is pending, which separate a stall on the named segment from a stall on all segments.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int SEG_N     = 6;
    localparam int SEG_IDX_W = 3;
    localparam int WORD_W    = 32;
    localparam int SEL_W     = 16;
    localparam int LIM_W     = 20;

    localparam logic [SEG_IDX_W-1:0] SEG_CS = 3'd1;
    localparam logic [SEG_IDX_W-1:0] SEG_FS = 3'd4;
    localparam logic [SEG_IDX_W-1:0] SEG_GS = 3'd5;

    typedef enum logic [2:0] {
        F_IDLE    = 3'd0,
        F_READ_LO = 3'd1,
        F_READ_HI = 3'd2,
        F_COMMIT  = 3'd3,
        F_REJECT  = 3'd4
    } fetch_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [1:0]        dpl;
        logic              exec;
    } shadow_t;

    localparam shadow_t SHADOW_RESET = '{base: '0, limit: '1, dpl: '0, exec: 1'b0};

endpackage

// File: rtl/seg_fetch_fsm.sv
module seg_fetch_fsm
    import seg_xlate_pkg::*;
#(
    parameter int MEM_AW = 32,
    parameter int TLIM_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_we,
    input  logic [SEG_IDX_W-1:0] sel_idx,
    input  logic [SEL_W-1:0]     sel_val,
    input  logic [MEM_AW-1:0]    gdt_base,
    input  logic [TLIM_W-1:0]    gdt_limit,
    input  logic [MEM_AW-1:0]    ldt_base,
    input  logic [TLIM_W-1:0]    ldt_limit,
    input  logic                 mem_rvalid,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 ld_ready,
    output logic                 load_fault,
    output logic                 mem_req,
    output logic [MEM_AW-1:0]    mem_addr,
    output logic                 commit_we,
    output logic [SEG_IDX_W-1:0] commit_idx,
    output logic [SEL_W-1:0]     commit_sel,
    output logic [WORD_W-1:0]    commit_lo,
    output logic [WORD_W-1:0]    commit_hi,
    output logic [SEG_N-1:0]     busy_vec
);

    localparam int IDX_W = SEL_W - 3;
    localparam int CMP_W = (TLIM_W > SEL_W) ? TLIM_W : SEL_W;

    fetch_state_e state_q, state_d;

    logic [SEG_IDX_W-1:0] tgt_q;
    logic [SEL_W-1:0]     sel_q;
    logic [MEM_AW-1:0]    addr_q;
    logic [WORD_W-1:0]    lo_q, hi_q;

    // Selector decode of the incoming write.
    logic [IDX_W-1:0]  wr_index;
    logic              wr_local;
    logic [TLIM_W-1:0] wr_tlimit;
    logic [MEM_AW-1:0] wr_tbase;
    logic [CMP_W-1:0]  wr_last_byte;
    logic              wr_out_of_table;
    logic              wr_bad_seg;
    logic              wr_reject;
    logic [MEM_AW-1:0] wr_desc_addr;

    always_comb begin
        wr_index        = sel_val[SEL_W-1:3];
        wr_local        = sel_val[2];
        wr_tlimit       = wr_local ? ldt_limit : gdt_limit;
        wr_tbase        = wr_local ? ldt_base : gdt_base;
        wr_last_byte    = CMP_W'({wr_index, 3'b111});
        wr_out_of_table = wr_last_byte > CMP_W'(wr_tlimit);
        wr_bad_seg      = sel_idx >= SEG_IDX_W'(SEG_N);
        wr_reject       = wr_bad_seg || wr_out_of_table;
        wr_desc_addr    = wr_tbase + MEM_AW'({wr_index, 3'b000});
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= F_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_IDLE: begin
                if (sel_we) state_d = wr_reject ? F_REJECT : F_READ_LO;
            end
            F_READ_LO: begin
                if (mem_rvalid) state_d = F_READ_HI;
            end
            F_READ_HI: begin
                if (mem_rvalid) state_d = F_COMMIT;
            end
            F_COMMIT: state_d = F_IDLE;
            F_REJECT: state_d = F_IDLE;
            default:  state_d = F_IDLE;
        endcase
    end

    // Capture registers of the fetch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            sel_q  <= '0;
            addr_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            if (state_q == F_IDLE && sel_we && !wr_reject) begin
                tgt_q  <= sel_idx;
                sel_q  <= sel_val;
                addr_q <= wr_desc_addr;
            end
            if (state_q == F_READ_LO && mem_rvalid) lo_q <= mem_rdata;
            if (state_q == F_READ_HI && mem_rvalid) hi_q <= mem_rdata;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        ld_ready   = 1'b0;
        load_fault = 1'b0;
        mem_req    = 1'b0;
        mem_addr   = addr_q;
        commit_we  = 1'b0;
        unique case (state_q)
            F_IDLE:    ld_ready = 1'b1;
            F_READ_LO: mem_req = 1'b1;
            F_READ_HI: begin
                mem_req  = 1'b1;
                mem_addr = addr_q + MEM_AW'(4);
            end
            F_COMMIT:  commit_we = 1'b1;
            F_REJECT:  load_fault = 1'b1;
            default:   ld_ready = 1'b0;
        endcase
    end

    assign commit_idx = tgt_q;
    assign commit_sel = sel_q;
    assign commit_lo  = lo_q;
    assign commit_hi  = hi_q;

    logic pending;
    assign pending = (state_q == F_READ_LO) || (state_q == F_READ_HI) || (state_q == F_COMMIT);

    for (genvar g = 0; g < SEG_N; g++) begin : g_busy
        assign busy_vec[g] = pending && (tgt_q == SEG_IDX_W'(g));
    end

endmodule

// File: rtl/seg_shadow_bank.sv
module seg_shadow_bank
    import seg_xlate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit_we,
    input  logic [SEG_IDX_W-1:0] commit_idx,
    input  logic [SEL_W-1:0]     commit_sel,
    input  logic [WORD_W-1:0]    commit_lo,
    input  logic [WORD_W-1:0]    commit_hi,
    output shadow_t              shadow_o [SEG_N],
    output logic [SEL_W-1:0]     sel_o    [SEG_N],
    output logic [1:0]           cpl
);

    shadow_t decoded;
    logic    desc_unused_bits;

    always_comb begin
        decoded.base  = {commit_hi[31:24], commit_hi[7:0], commit_lo[31:16]};
        decoded.limit = {commit_hi[19:16], commit_lo[15:0]};
        decoded.dpl   = commit_hi[14:13];
        decoded.exec  = commit_hi[11];
    end

    assign desc_unused_bits = ^{commit_hi[23:20], commit_hi[15], commit_hi[12], commit_hi[10:8]};

    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_o[g] <= SHADOW_RESET;
                sel_o[g]    <= '0;
            end else if (commit_we && commit_idx == SEG_IDX_W'(g)) begin
                shadow_o[g] <= decoded;
                sel_o[g]    <= commit_sel;
            end
        end
    end

    assign cpl = sel_o[SEG_CS][1:0];

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_xlate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode64,
    input  logic                 xl_valid,
    input  logic [SEG_IDX_W-1:0] xl_seg,
    input  logic [WORD_W-1:0]    xl_off,
    input  shadow_t              shadow_i [SEG_N],
    input  logic [SEL_W-1:0]     sel_i    [SEG_N],
    input  logic [SEG_N-1:0]     busy_vec,
    output logic                 xl_ready,
    output logic                 lin_valid,
    output logic [WORD_W-1:0]    lin_addr,
    output logic                 lin_fault,
    output logic [1:0]           lin_dpl,
    output logic                 lin_exec,
    output logic [SEL_W-1:0]     lin_sel
);

    shadow_t           pick;
    logic [SEL_W-1:0]  pick_sel;
    logic              busy_hit;
    logic              seg_ok;
    logic              keeps_base;
    logic [WORD_W-1:0] eff_base;
    logic              over_limit;
    logic              accept;

    always_comb begin
        pick     = '0;
        pick_sel = '0;
        busy_hit = 1'b0;
        for (int i = 0; i < SEG_N; i++) begin
            if (xl_seg == SEG_IDX_W'(i)) begin
                pick     = shadow_i[i];
                pick_sel = sel_i[i];
                busy_hit = busy_vec[i];
            end
        end
        seg_ok     = xl_seg < SEG_IDX_W'(SEG_N);
        keeps_base = !mode64 || xl_seg == SEG_FS || xl_seg == SEG_GS;
        eff_base   = (seg_ok && keeps_base) ? pick.base : '0;
        over_limit = xl_off > WORD_W'(pick.limit);
        xl_ready   = !busy_hit;
        accept     = xl_valid && xl_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lin_valid <= 1'b0;
            lin_addr  <= '0;
            lin_fault <= 1'b0;
            lin_dpl   <= '0;
            lin_exec  <= 1'b0;
            lin_sel   <= '0;
        end else begin
            lin_valid <= accept;
            if (accept) begin
                lin_addr  <= eff_base + xl_off;
                lin_fault <= !seg_ok || (!mode64 && over_limit);
                lin_dpl   <= pick.dpl;
                lin_exec  <= pick.exec;
                lin_sel   <= pick_sel;
            end
        end
    end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int MEM_AW = 32,
    parameter int TLIM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode64,
    input  logic [MEM_AW-1:0] gdt_base,
    input  logic [TLIM_W-1:0] gdt_limit,
    input  logic [MEM_AW-1:0] ldt_base,
    input  logic [TLIM_W-1:0] ldt_limit,
    input  logic              sel_we,
    input  logic [2:0]        sel_idx,
    input  logic [15:0]       sel_val,
    output logic              ld_ready,
    output logic              load_fault,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              xl_valid,
    input  logic [2:0]        xl_seg,
    input  logic [31:0]       xl_off,
    output logic              xl_ready,
    output logic              lin_valid,
    output logic [31:0]       lin_addr,
    output logic              lin_fault,
    output logic [1:0]        lin_dpl,
    output logic              lin_exec,
    output logic [15:0]       lin_sel,
    output logic [5:0]        seg_busy,
    output logic [1:0]        cpl
);

    logic                 commit_we;
    logic [SEG_IDX_W-1:0] commit_idx;
    logic [SEL_W-1:0]     commit_sel;
    logic [WORD_W-1:0]    commit_lo, commit_hi;
    shadow_t              shadow_w [SEG_N];
    logic [SEL_W-1:0]     sel_w    [SEG_N];

    seg_fetch_fsm #(.MEM_AW(MEM_AW), .TLIM_W(TLIM_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_we     (sel_we),
        .sel_idx    (sel_idx),
        .sel_val    (sel_val),
        .gdt_base   (gdt_base),
        .gdt_limit  (gdt_limit),
        .ldt_base   (ldt_base),
        .ldt_limit  (ldt_limit),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .ld_ready   (ld_ready),
        .load_fault (load_fault),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .commit_we  (commit_we),
        .commit_idx (commit_idx),
        .commit_sel (commit_sel),
        .commit_lo  (commit_lo),
        .commit_hi  (commit_hi),
        .busy_vec   (seg_busy)
    );

    seg_shadow_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_we  (commit_we),
        .commit_idx (commit_idx),
        .commit_sel (commit_sel),
        .commit_lo  (commit_lo),
        .commit_hi  (commit_hi),
        .shadow_o   (shadow_w),
        .sel_o      (sel_w),
        .cpl        (cpl)
    );

    seg_addr_gen u_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode64    (mode64),
        .xl_valid  (xl_valid),
        .xl_seg    (xl_seg),
        .xl_off    (xl_off),
        .shadow_i  (shadow_w),
        .sel_i     (sel_w),
        .busy_vec  (seg_busy),
        .xl_ready  (xl_ready),
        .lin_valid (lin_valid),
        .lin_addr  (lin_addr),
        .lin_fault (lin_fault),
        .lin_dpl   (lin_dpl),
        .lin_exec  (lin_exec),
        .lin_sel   (lin_sel)
    );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode64,
    input logic       sel_we,
    input logic       ld_ready,
    input logic       load_fault,
    input logic       mem_req,
    input logic       xl_valid,
    input logic [2:0] xl_seg,
    input logic       xl_ready,
    input logic       lin_valid,
    input logic       lin_fault,
    input logic [5:0] seg_busy,
    input logic [1:0] cpl
);

    AST_REQ_ONLY_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ld_ready); // R8

    AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && xl_ready) |=> lin_valid); // R5

    AST_NO_RESULT_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_valid && xl_ready) |=> !lin_valid); // R5

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seg_busy)); // R6

    AST_BUSY_STALLS_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (|(seg_busy & (6'b1 << xl_seg))) |-> !xl_ready); // R6

    AST_FAULT_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        load_fault |-> !mem_req); // R7

    AST_FAULT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load_fault |-> $past(sel_we)); // R7

    AST_FLAT_NO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && xl_ready && mode64 && xl_seg < 3'd6) |=> !lin_fault); // R4

    AST_CPL_ON_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl != $past(cpl)) |-> !$past(ld_ready)); // R10

endmodule

bind seg_xlate_top seg_xlate_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode64     (mode64),
    .sel_we     (sel_we),
    .ld_ready   (ld_ready),
    .load_fault (load_fault),
    .mem_req    (mem_req),
    .xl_valid   (xl_valid),
    .xl_seg     (xl_seg),
    .xl_ready   (xl_ready),
    .lin_valid  (lin_valid),
    .lin_fault  (lin_fault),
    .seg_busy   (seg_busy),
    .cpl        (cpl)
);

// File: tb/seg_xlate_top_tb_top.sv
module seg_xlate_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode64 = 1'b0;
    logic [31:0] gdt_base = 32'h0001_0000;
    logic [15:0] gdt_limit = 16'h00FF;
    logic [31:0] ldt_base = 32'h0040_0800;
    logic [15:0] ldt_limit = 16'h003F;
    logic        sel_we = 1'b0;
    logic [2:0]  sel_idx = '0;
    logic [15:0] sel_val = '0;
    logic        ld_ready, load_fault, mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        xl_valid = 1'b0;
    logic [2:0]  xl_seg = '0;
    logic [31:0] xl_off = '0;
    logic        xl_ready, lin_valid, lin_fault, lin_exec;
    logic [31:0] lin_addr;
    logic [1:0]  lin_dpl, cpl;
    logic [15:0] lin_sel;
    logic [5:0]  seg_busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_base  [6];
    logic [19:0] m_limit [6];
    logic [1:0]  m_dpl   [6];
    logic        m_exec  [6];
    logic [15:0] m_sel   [6];

    logic [31:0] rd_log [2];
    int          rd_cnt = 0;
    int          lat = 0;

    always #5 clk = ~clk;

    seg_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode64(mode64),
        .gdt_base(gdt_base), .gdt_limit(gdt_limit),
        .ldt_base(ldt_base), .ldt_limit(ldt_limit),
        .sel_we(sel_we), .sel_idx(sel_idx), .sel_val(sel_val),
        .ld_ready(ld_ready), .load_fault(load_fault),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .xl_valid(xl_valid), .xl_seg(xl_seg), .xl_off(xl_off),
        .xl_ready(xl_ready), .lin_valid(lin_valid), .lin_addr(lin_addr),
        .lin_fault(lin_fault), .lin_dpl(lin_dpl), .lin_exec(lin_exec),
        .lin_sel(lin_sel), .seg_busy(seg_busy), .cpl(cpl)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ (a >> 3) ^ 32'h1357_9BDF;
    endfunction

    // Memory model with a random response delay of 0 to 2 cycles.
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(posedge clk);
            #1;
            if (mem_rvalid) mem_rvalid = 1'b0;
            else if (mem_req) begin
                if (lat == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem_word(mem_addr);
                    if (rd_cnt < 2) rd_log[rd_cnt] = mem_addr;
                    rd_cnt++;
                    lat = $urandom_range(0, 2);
                end else lat--;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (!ld_ready && guard < 100) begin
            @(posedge clk);
            #1;
            guard++;
        end
        check(ld_ready, "R6", "loader did not return to idle", 32'(ld_ready), 1);
    endtask

    task automatic do_load(input logic [2:0] idx, input logic [15:0] val);
        logic [31:0] tb, a, lo, hi;
        logic [15:0] tl;
        bit          exp_fault;
        tb = val[2] ? ldt_base : gdt_base;
        tl = val[2] ? ldt_limit : gdt_limit;
        exp_fault = (idx >= 3'd6) || ({val[15:3], 3'b111} > tl);
        a = tb + {16'b0, val[15:3], 3'b000};
        wait_idle();
        rd_cnt = 0;
        sel_we = 1'b1; sel_idx = idx; sel_val = val;
        @(posedge clk);
        #1;
        sel_we = 1'b0;
        check(load_fault == exp_fault, "R7", "load_fault after write", 32'(load_fault), 32'(exp_fault));
        if (exp_fault) begin
            check(!mem_req, "R7", "read issued on rejected load", 32'(mem_req), 0);
            @(posedge clk);
            #1;
            check(rd_cnt == 0, "R7", "reads on rejected load", rd_cnt, 0);
        end else begin
            wait_idle();
            check(rd_cnt == 2, "R1", "descriptor read count", rd_cnt, 2);
            check(rd_log[0] == a, "R1", "low word address", rd_log[0], a);
            check(rd_log[1] == a + 4, "R1", "high word address", rd_log[1], a + 4);
            lo = mem_word(a);
            hi = mem_word(a + 4);
            m_base[idx]  = {hi[31:24], hi[7:0], lo[31:16]};
            m_limit[idx] = {hi[19:16], lo[15:0]};
            m_dpl[idx]   = hi[14:13];
            m_exec[idx]  = hi[11];
            m_sel[idx]   = val;
        end
    endtask

    task automatic do_xl(input logic [2:0] seg, input logic [31:0] off, input bit m64);
        logic [31:0] e_addr;
        bit          e_fault;
        int          guard = 0;
        if (seg >= 3'd6) begin
            e_addr = off; e_fault = 1'b1;
        end else begin
            e_addr  = ((!m64 || seg >= 3'd4) ? m_base[seg] : 32'h0) + off;
            e_fault = !m64 && (off > {12'b0, m_limit[seg]});
        end
        mode64 = m64; xl_seg = seg; xl_off = off; xl_valid = 1'b1;
        #1;
        while (!xl_ready && guard < 100) begin
            @(posedge clk);
            #1;
            guard++;
        end
        @(posedge clk);
        #1;
        xl_valid = 1'b0;
        check(lin_valid, "R5", "lin_valid after accept", 32'(lin_valid), 1);
        check(lin_addr == e_addr, m64 ? "R4" : "R3", "lin_addr", lin_addr, e_addr);
        check(lin_fault == e_fault, (seg >= 3'd6) ? "R12" : (m64 ? "R4" : "R3"), "lin_fault",
              32'(lin_fault), 32'(e_fault));
        if (seg < 3'd6) begin
            check(lin_dpl == m_dpl[seg] && lin_exec == m_exec[seg] && lin_sel == m_sel[seg],
                  "R2", "dpl/exec/sel", {13'b0, lin_dpl, lin_exec, lin_sel},
                  {13'b0, m_dpl[seg], m_exec[seg], m_sel[seg]});
        end
        @(posedge clk);
        #1;
        check(!lin_valid, "R5", "lin_valid without request", 32'(lin_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run timed out", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 6; i++) begin
            m_base[i] = '0; m_limit[i] = 20'hFFFFF; m_dpl[i] = '0; m_exec[i] = 1'b0; m_sel[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R11: reset state
        check(ld_ready && !mem_req && seg_busy == 0 && cpl == 0, "R11", "reset outputs",
              {24'b0, ld_ready, mem_req, seg_busy}, 32'h80);
        do_xl(3'd3, 32'h0000_1234, 1'b0);   // R11 flat reset cache
        do_xl(3'd3, 32'h0010_0000, 1'b0);   // R11 reset limit + 1
        do_xl(3'd3, 32'h000F_FFFF, 1'b0);   // R11 reset limit exactly

        // R10: privilege from CS
        do_load(3'd1, {13'd5, 1'b0, 2'd3});
        check(cpl == 2'd3, "R10", "cpl after CS load", 32'(cpl), 3);
        do_load(3'd3, {13'd7, 1'b0, 2'd1});
        check(cpl == 2'd3, "R10", "cpl after DS load", 32'(cpl), 3);

        // R7: table boundaries and bad segment number
        do_load(3'd2, {13'd31, 1'b0, 2'd0});
        do_load(3'd2, {13'd32, 1'b0, 2'd0});
        do_load(3'd0, {13'd7, 1'b1, 2'd2});
        do_load(3'd0, {13'd8, 1'b1, 2'd2});
        do_load(3'd6, {13'd1, 1'b0, 2'd0});
        do_xl(3'd2, 32'h10, 1'b0);
        do_xl(3'd0, 32'h10, 1'b0);

        // R3/R4: limit edges in both modes, FS/GS base kept in 64-bit mode
        do_load(3'd4, {13'd3, 1'b1, 2'd0});
        do_load(3'd5, {13'd9, 1'b0, 2'd2});
        do_xl(3'd4, {12'b0, m_limit[4]}, 1'b0);
        do_xl(3'd4, {12'b0, m_limit[4]} + 1, 1'b0);
        do_xl(3'd4, {12'b0, m_limit[4]} + 1, 1'b1);
        do_xl(3'd5, 32'hFFFF_FFF0, 1'b1);
        do_xl(3'd3, {12'b0, m_limit[3]} + 1, 1'b1);
        do_xl(3'd1, 32'h8000_0000, 1'b1);

        // R12: segment numbers 6 and 7
        do_xl(3'd6, 32'hDEAD_0000, 1'b0);
        do_xl(3'd7, 32'h0000_BEEF, 1'b1);

        // R6/R9: stall only the loading segment, ignore writes while busy
        wait_idle();
        sel_we = 1'b1; sel_idx = 3'd3; sel_val = {13'd12, 1'b0, 2'd0};
        @(posedge clk);
        #1;
        sel_we = 1'b0;
        check(seg_busy == 6'b001000, "R6", "busy vector", 32'(seg_busy), 32'h08);
        check(!ld_ready, "R9", "ld_ready during fetch", 32'(ld_ready), 0);
        xl_seg = 3'd3;
        #1;
        check(!xl_ready, "R6", "ready for loading segment", 32'(xl_ready), 0);
        xl_seg = 3'd0;
        #1;
        check(xl_ready, "R6", "ready for other segment", 32'(xl_ready), 1);
        @(posedge clk);
        #1;
        sel_we = 1'b1; sel_idx = 3'd5; sel_val = {13'd20, 1'b0, 2'd1};
        @(posedge clk);
        #1;
        sel_we = 1'b0;
        wait_idle();
        begin
            logic [31:0] a, lo, hi;
            a = gdt_base + {16'b0, 13'd12, 3'b000};
            lo = mem_word(a); hi = mem_word(a + 4);
            m_base[3] = {hi[31:24], hi[7:0], lo[31:16]};
            m_limit[3] = {hi[19:16], lo[15:0]};
            m_dpl[3] = hi[14:13]; m_exec[3] = hi[11];
            m_sel[3] = {13'd12, 1'b0, 2'd0};
        end
        do_xl(3'd5, 32'h40, 1'b0);   // R9 GS unchanged
        do_xl(3'd3, 32'h40, 1'b0);   // R6 DS now loaded

        // Random mix
        for (int n = 0; n < 150; n++) begin
            if ($urandom_range(0, 2) == 0) begin
                logic [2:0]  ri;
                logic [15:0] rv;
                ri = 3'($urandom_range(0, 6));
                rv = {13'($urandom_range(0, 39)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3))};
                do_load(ri, rv);
                check(cpl == m_sel[1][1:0], "R10", "cpl tracks CS", 32'(cpl), 32'(m_sel[1][1:0]));
            end else begin
                logic [2:0]  rs;
                logic [31:0] ro;
                int          pick;
                rs = 3'($urandom_range(0, 6));
                pick = $urandom_range(0, 2);
                if (rs < 3'd6 && pick == 0)      ro = {12'b0, m_limit[rs]};
                else if (rs < 3'd6 && pick == 1) ro = {12'b0, m_limit[rs]} + 1;
                else                             ro = $urandom;
                do_xl(rs, ro, 1'($urandom_range(0, 1)));
            end
        end

        finish_run();
    end

endmodule